// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Update Window

This block sits between a slow oscillator tick and the time-of-day digit counters of a real-time clock. Each time `tick_i` is high for a cycle, it advances a chain of binary divider stages. When the whole chain rolls over from all ones to zero, the block emits a single-cycle count-advance pulse. With the defaults, 15 stages are fed by a 32.768 kHz tick, so the pulse comes once per second.

Shortly before every rollover, an active-low window on `busy_no` tells software that the digit counters are about to change. Reads and writes should wait until the window closes.

A clear request zeroes only the upper stages. The lower stages keep running, so the next rollover after release arrives one full second later, minus the phase the lower stages already held. While the request is held, the update window stays closed and no advance is produced.

A four-bit reference word can be read back. It carries a fast square wave, the one-second square wave, a flag for the first second of each minute, and a flag for the first second of each hour. A stop input holds the time-of-day chain still. It suppresses the advance pulse and freezes the minute and hour prescalers, but the divider and the update window keep running.

Top module: `rtc_divider`

## Requirements
- R1: Every cycle with `tick_i` high advances the low `STAGES-CLR_STAGES` divider stages by one, whether or not a clear is requested. `ref_o[0]` shows the level of stage `FAST_TAP` (bit `FAST_TAP` of the divider, counting from 0).
- R2: `ref_o[1]` shows the level of the most significant divider stage. Without a clear it has a period of `2**STAGES` ticks, and cycles without a tick change nothing.
- R3: `adv_o` is high for exactly one cycle, in the cycle after the edge at which a tick moves the divider from all ones to zero.
- R4: While `stop_i` is high at that edge, `adv_o` stays low and the minute/hour prescalers hold. The divider and `busy_no` carry on unchanged.
- R5: `busy_no` goes low when the divider reaches `2**STAGES-BUSY_LEAD`, which is `BUSY_LEAD` ticks before the rollover. It stays low for `BUSY_LEN` ticks in total.
- R6: While `clr_req_i` is high, the top `CLR_STAGES` stages are held at zero, no advance is produced, and `busy_no` is high from the next cycle. A clear during an open window closes it.
- R7: After a clear is released with the low stages at phase L, `busy_no` stays high for `2**STAGES-BUSY_LEAD-L` ticks and then falls. `adv_o` fires after `2**STAGES-L` ticks.
- R8: Advance pulses step a seconds prescaler modulo `SEC_DIV`. `ref_o[2]` is high while that prescaler is zero.
- R9: Each wrap of the seconds prescaler steps a minutes prescaler modulo `MIN_DIV`. `ref_o[3]` is high while both prescalers are zero.
- R10: After `rst_ni` the divider and both prescalers are zero, `adv_o` is low, `busy_no` is high and `ref_o` is `4'b1100`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable per oscillator period |
| clr_req_i | input | 1 | Level request clearing the upper divider stages |
| stop_i | input | 1 | High suppresses the advance pulse and freezes the prescalers |
| adv_o | output | 1 | One-cycle count-advance pulse at divider rollover |
| busy_no | output | 1 | Active-low update window around the rollover |
| ref_o | output | 4 | Reference word: {hour flag, minute flag, slow wave, fast wave} |

## Verification
The bench builds the block with `STAGES=6`, `CLR_STAGES=2`, `FAST_TAP=1`, `BUSY_LEAD=3`, `BUSY_LEN=5`, `SEC_DIV=3` and `MIN_DIV=2`. A "second" is then 64 ticks and an "hour" is 384 ticks. This makes it feasible to release the clear from every one of the 16 low-stage phases and to measure both release latencies exactly. It also lets minute and hour wraps, windows that straddle the rollover, stop toggling and irregular tick spacing all occur many times within a short run.

// File: rtl/rtc_divider_pkg.sv
package rtc_divider_pkg;

    // Bit layout of the reference word; software decodes these positions.
    typedef struct packed {
        logic hour_flag;   // bit 3
        logic min_flag;    // bit 2
        logic slow_wave;   // bit 1
        logic fast_wave;   // bit 0
    } ref_word_t;

    localparam ref_word_t REF_RESET = '{hour_flag: 1'b1, min_flag: 1'b1,
                                        slow_wave: 1'b0, fast_wave: 1'b0};

endpackage

// File: rtl/rtc_div_stages.sv
module rtc_div_stages #(
    parameter int STAGES     = 15,
    parameter int CLR_STAGES = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              clr_i,
    output logic [STAGES-1:0] cnt_q_o,
    output logic [STAGES-1:0] cnt_d_o,
    output logic              wrap_o
);

    localparam int LOW = STAGES - CLR_STAGES;

    typedef struct packed {
        logic [STAGES-1:0] cnt;
    } stage_st_t;

    stage_st_t st_d, st_q;
    logic [STAGES:0] carry;

    // Ripple enable: a stage toggles when the tick reaches it through all lower ones.
    assign carry[0] = tick_i;
    for (genvar g = 0; g < STAGES; g++) begin : g_carry
        assign carry[g+1] = carry[g] & st_q.cnt[g];
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < STAGES; i++) begin
            if ((i >= LOW) && clr_i) begin
                st_d.cnt[i] = 1'b0;
            end else begin
                st_d.cnt[i] = st_q.cnt[i] ^ carry[i];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q_o = st_q.cnt;
    assign cnt_d_o = st_d.cnt;
    assign wrap_o  = carry[STAGES] & ~clr_i;

endmodule

// File: rtl/rtc_div_busy.sv
module rtc_div_busy #(
    parameter int STAGES    = 15,
    parameter int BUSY_LEAD = 8,
    parameter int BUSY_LEN  = 14
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic [STAGES-1:0] cnt_d_i,
    output logic              busy_no
);

    localparam logic [STAGES-1:0] START = STAGES'((1 << STAGES) - BUSY_LEAD);
    localparam logic [STAGES:0]   LEN_W = (STAGES + 1)'(BUSY_LEN);

    typedef struct packed {
        logic armed;
        logic busy_n;
    } busy_st_t;

    busy_st_t st_d, st_q;
    logic [STAGES-1:0] offset;
    logic              hit;
    logic              in_win;

    always_comb begin
        st_d   = st_q;
        offset = cnt_d_i - START;
        hit    = (cnt_d_i == START);
        in_win = ({1'b0, offset} < LEN_W);
        if (clr_i) begin
            st_d.armed  = 1'b0;
            st_d.busy_n = 1'b1;
        end else begin
            st_d.armed  = st_q.armed | hit;
            st_d.busy_n = ~((st_q.armed | hit) & in_win);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{armed: 1'b0, busy_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_no = st_q.busy_n;

endmodule

// File: rtl/rtc_div_ref.sv
module rtc_div_ref
    import rtc_divider_pkg::*;
#(
    parameter int SEC_DIV = 60,
    parameter int MIN_DIV = 60
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      wrap_i,
    input  logic      stop_i,
    input  logic      slow_i,
    input  logic      fast_i,
    output logic      adv_o,
    output ref_word_t ref_o
);

    localparam int SW = (SEC_DIV > 1) ? $clog2(SEC_DIV) : 1;
    localparam int MW = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1;
    localparam logic [SW-1:0] SEC_LAST = SW'(SEC_DIV - 1);
    localparam logic [MW-1:0] MIN_LAST = MW'(MIN_DIV - 1);

    typedef struct packed {
        logic          adv;
        logic [SW-1:0] sec;
        logic [MW-1:0] mins;
    } ref_st_t;

    ref_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.adv = wrap_i & ~stop_i;
        if (st_d.adv) begin
            if (st_q.sec == SEC_LAST) begin
                st_d.sec  = '0;
                st_d.mins = (st_q.mins == MIN_LAST) ? '0 : st_q.mins + 1'b1;
            end else begin
                st_d.sec = st_q.sec + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign adv_o = st_q.adv;
    assign ref_o = '{hour_flag: (st_q.sec == '0) && (st_q.mins == '0),
                     min_flag:  (st_q.sec == '0),
                     slow_wave: slow_i,
                     fast_wave: fast_i};

endmodule

// File: rtl/rtc_divider.sv
module rtc_divider
    import rtc_divider_pkg::*;
#(
    parameter int STAGES     = 15,
    parameter int CLR_STAGES = 5,
    parameter int FAST_TAP   = 4,
    parameter int BUSY_LEAD  = 8,
    parameter int BUSY_LEN   = 14,
    parameter int SEC_DIV    = 60,
    parameter int MIN_DIV    = 60
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       clr_req_i,
    input  logic       stop_i,
    output logic       adv_o,
    output logic       busy_no,
    output logic [3:0] ref_o
);

    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] cnt_d;
    logic              wrap;
    ref_word_t         ref_w;

    rtc_div_stages #(
        .STAGES    (STAGES),
        .CLR_STAGES(CLR_STAGES)
    ) i_stages (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .clr_i  (clr_req_i),
        .cnt_q_o(cnt_q),
        .cnt_d_o(cnt_d),
        .wrap_o (wrap)
    );

    rtc_div_busy #(
        .STAGES   (STAGES),
        .BUSY_LEAD(BUSY_LEAD),
        .BUSY_LEN (BUSY_LEN)
    ) i_busy (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_req_i),
        .cnt_d_i(cnt_d),
        .busy_no(busy_no)
    );

    rtc_div_ref #(
        .SEC_DIV(SEC_DIV),
        .MIN_DIV(MIN_DIV)
    ) i_ref (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .wrap_i(wrap),
        .stop_i(stop_i),
        .slow_i(cnt_q[STAGES-1]),
        .fast_i(cnt_q[FAST_TAP]),
        .adv_o (adv_o),
        .ref_o (ref_w)
    );

    assign ref_o = ref_w;

endmodule

// File: rtl/rtc_divider_chk.sv
module rtc_divider_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       tick_i,
    input logic       clr_req_i,
    input logic       stop_i,
    input logic       adv_o,
    input logic       busy_no,
    input logic [3:0] ref_o
);

    AST_ADV_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_o |=> !adv_o); // R3

    AST_ADV_AT_ROLLOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_o |-> (!ref_o[1] && $past(ref_o[1]))); // R3

    AST_STOP_MUTES_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> !adv_o); // R4

    AST_CLR_CLOSES_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_req_i |=> busy_no); // R6

    AST_CLR_NO_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_req_i |=> (!adv_o && !ref_o[1])); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !clr_req_i) |=> ($stable(ref_o) && !adv_o)); // R2

    AST_WINDOW_BEFORE_ROLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_no) |-> ref_o[1]); // R5

endmodule

bind rtc_divider rtc_divider_chk i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .clr_req_i(clr_req_i),
    .stop_i   (stop_i),
    .adv_o    (adv_o),
    .busy_no  (busy_no),
    .ref_o    (ref_o)
);

// File: tb/test_rtc_divider.sv
module test_rtc_divider;

    localparam int S    = 6;
    localparam int CS   = 2;
    localparam int FT   = 1;
    localparam int LEAD = 3;
    localparam int LEN  = 5;
    localparam int SD   = 3;
    localparam int MD   = 2;
    localparam int MOD  = 1 << S;
    localparam int LOWM = 1 << (S - CS);
    localparam int START = MOD - LEAD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       clr = 1'b0;
    logic       stop = 1'b0;
    logic       adv;
    logic       busy_n;
    logic [3:0] refw;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    int m_cnt   = 0;
    int m_sec   = 0;
    int m_min   = 0;
    bit m_adv   = 1'b0;
    bit m_busyn = 1'b1;
    bit m_armed = 1'b0;

    always #4 clk = ~clk;

    rtc_divider #(
        .STAGES(S), .CLR_STAGES(CS), .FAST_TAP(FT),
        .BUSY_LEAD(LEAD), .BUSY_LEN(LEN), .SEC_DIV(SD), .MIN_DIV(MD)
    ) i_rtc_divider (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .clr_req_i(clr),
        .stop_i(stop), .adv_o(adv), .busy_no(busy_n), .ref_o(refw)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare_all(input bit c, input bit s);
        chk(s ? "R4 adv" : "R3 adv", int'(adv), int'(m_adv));
        chk(c ? "R6 busy" : "R5 busy", int'(busy_n), int'(m_busyn));
        chk("R1 fast wave", int'(refw[0]), (m_cnt >> FT) & 1);
        chk("R2 slow wave", int'(refw[1]), (m_cnt >> (S - 1)) & 1);
        chk("R8 minute flag", int'(refw[2]), int'(m_sec == 0));
        chk("R9 hour flag", int'(refw[3]), int'(m_sec == 0 && m_min == 0));
    endtask

    // Apply one cycle of inputs, advance the model, sample after the edge.
    task automatic step(input bit t, input bit c, input bit s);
        int lo, up, ncnt, off;
        bit wrap, hit, win;
        tick = t; clr = c; stop = s;
        @(posedge clk);
        lo   = m_cnt % LOWM;
        up   = m_cnt / LOWM;
        wrap = t && !c && (m_cnt == MOD - 1);
        lo   = t ? (lo + 1) % LOWM : lo;
        if (c) up = 0;
        else if (t && (m_cnt % LOWM) == LOWM - 1) up = (up + 1) % (MOD / LOWM);
        ncnt  = up * LOWM + lo;
        m_adv = wrap && !s;
        if (m_adv) begin
            if (m_sec == SD - 1) begin
                m_sec = 0;
                m_min = (m_min == MD - 1) ? 0 : m_min + 1;
            end else begin
                m_sec = m_sec + 1;
            end
        end
        hit     = (ncnt == START);
        off     = (ncnt - START + MOD) % MOD;
        win     = off < LEN;
        m_busyn = !(!c && (m_armed || hit) && win);
        m_armed = c ? 1'b0 : (m_armed || hit);
        m_cnt   = ncnt;
        #2;
        compare_all(c, s);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        int lrel, nb, na;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk("R10 adv", int'(adv), 0);
        chk("R10 busy", int'(busy_n), 1);
        chk("R10 ref", int'(refw), 12);

        // Steady ticks across two full hours
        for (int i = 0; i < 2 * MOD * SD * MD; i++) step(1'b1, 1'b0, 1'b0);

        // Sparse ticks with stop toggling
        for (int i = 0; i < 900; i++) step((i % 3) != 0, 1'b0, ((i / 70) % 2) == 1);

        // R7: release the clear from every low-stage phase
        for (int l = 0; l < LOWM; l++) begin
            step(1'b1, 1'b0, 1'b0);
            while ((m_cnt % LOWM) != l) step(1'b1, 1'b0, 1'b0);
            for (int k = 0; k < 3; k++) step(k[0], 1'b1, 1'b0);
            lrel = m_cnt;
            nb = 0; na = 0;
            for (int k = 1; k <= MOD + 2; k++) begin
                step(1'b1, 1'b0, 1'b0);
                if (nb == 0 && !busy_n) nb = k;
                if (na == 0 && adv) na = k;
            end
            chk("R7 busy latency", nb, MOD - LEAD - lrel);
            chk("R7 adv latency", na, MOD - lrel);
        end

        // R6: clear arriving inside an open window
        while (m_cnt != START + 1) step(1'b1, 1'b0, 1'b0);
        chk("R5 window open", int'(busy_n), 0);
        step(1'b1, 1'b1, 1'b0);
        chk("R6 window closed by clear", int'(busy_n), 1);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0);
        chk("R6 no window right after release", int'(busy_n), 1);

        // Irregular traffic
        lfsr = 8'hA5;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0] | lfsr[1], (lfsr[7:2] == 6'h3F), ((i / 200) % 3) == 2);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule